// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block sequences five dual-purpose pads after power-good or reset. For a fixed window of core clock cycles the pad drivers stay three-stated and the clock outputs that share those pads are held low. During this time external pull resistors set each pad level. Each pad level passes through a synchronizer. At the end of the window the synchronized levels are captured into a strap register. One cycle later the output drivers are enabled and the clock hold is released.

The captured straps give the power-up frequency code (three bits), a pin-function mode bit and a CPU output-swing select bit. They keep their values until the next reset, which stands for a power cycle. The effective frequency code comes from the straps unless a register override bit is set. In that case a three-bit register value replaces the straps, and clearing the override restores the strap code.

Top module: `strap_seq`

## Requirements
- R1: While reset is asserted, `pad_oe` is 0, `clk_hold` is 1, `strap_valid` is 0 and `strap_mode`, `swing_2v5` and the strap part of `fsel_eff` are 0.
- R2: After reset is released, `pad_oe` stays 0, `clk_hold` stays 1 and `strap_valid` stays 0 through the first WINDOW_CYCLES-1 rising clock edges.
- R3: At rising edge WINDOW_CYCLES after reset release, `strap_valid` goes to 1 and the synchronized pad levels are captured. The field layout of `pad_in` is bits [2:0] frequency code, bit 3 mode, bit 4 swing select.
- R4: `pad_oe` goes to 1 and `clk_hold` goes to 0 at the rising edge after `strap_valid` rises, and both stay there until reset.
- R5: Changes on `pad_in` after the capture have no effect on `strap_mode`, `swing_2v5` or the strap frequency code until the next reset.
- R6: With `reg_override`=0, `fsel_eff` equals the captured frequency code. With `reg_override`=1 it equals `reg_fsel`. Returning the override to 0 restores the captured code.
- R7: `swing_2v5`=1 selects 2.5 V CPU output swing and 0 selects 3.3 V. It equals the captured bit 4 of `pad_in`.
- R8: With two synchronizer stages, a pad level captured at edge WINDOW_CYCLES is the level sampled at edge WINDOW_CYCLES-2. A change made after that edge is not captured, and a change made before it is.
- R9: A reset after the straps are valid clears them and restarts the full window, and the new pad levels are then captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-good / reset |
| pad_in | input | 5 | Pad levels: [2:0] freq code, [3] mode, [4] swing select |
| reg_override | input | 1 | 1: frequency code taken from `reg_fsel` |
| reg_fsel | input | 3 | Register-written frequency code |
| pad_oe | output | 1 | Pad output driver enable |
| clk_hold | output | 1 | 1: shared clock outputs held low |
| strap_valid | output | 1 | Straps captured and usable |
| fsel_eff | output | 3 | Effective frequency code (one of eight settings) |
| strap_mode | output | 1 | Captured pin-function mode bit |
| swing_2v5 | output | 1 | Captured swing select, 1 = 2.5 V |

## Verification
The hardest case to reach is a pad change that lands right at the synchronizer boundary just before the capture edge. Only the pad level from two edges before the capture may be latched. The bench releases reset on a falling edge and counts rising edges exactly. It changes a pad one falling edge after edge WINDOW_CYCLES-2 and, in a second run, one falling edge after edge WINDOW_CYCLES-3. It then checks that the old value is captured in the first run and the new value in the second. A reset after the straps are valid, with different pad levels, shows that the straps are cleared and captured again.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  localparam int STRAP_W = 5;
  localparam int FSEL_W  = 3;

  typedef struct packed {
    logic              swing;
    logic              mode;
    logic [FSEL_W-1:0] fsel;
  } strap_t;

  typedef enum logic [1:0] {
    PH_SAMPLE  = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_RUN     = 2'd2
  } phase_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in[b]};
      end
      assign sync_out[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/window_timer.sv
module window_timer
  import strap_seq_pkg::*;
#(
  parameter int WINDOW_CYCLES = 66000
) (
  input  logic   clk,
  input  logic   rst_n,
  output logic   capture,
  output phase_e phase
);
  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign capture = (phase == PH_SAMPLE) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_SAMPLE;
    end else begin
      unique case (phase)
        PH_SAMPLE: begin
          if (capture) phase <= PH_CAPTURE;
          else         cnt   <= cnt + 1'b1;
        end
        PH_CAPTURE: phase <= PH_RUN;
        default:    phase <= PH_RUN;
      endcase
    end
  end

  a_r4_capture_then_run: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CAPTURE) |=> (phase == PH_RUN));
  a_r4_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  strap_t d,
  output strap_t q,
  output logic   valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (capture && !valid) begin
      q     <= d;
      valid <= 1'b1;
    end
  end

  a_r5_hold_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> ($stable(q) && valid));
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
  import strap_seq_pkg::*;
(
  input  logic [FSEL_W-1:0] strap_fsel,
  input  logic              override,
  input  logic [FSEL_W-1:0] reg_fsel,
  output logic [FSEL_W-1:0] fsel
);
  always_comb begin
    if (override) fsel = reg_fsel;
    else          fsel = strap_fsel;
  end
endmodule

// File: rtl/strap_seq.sv
module strap_seq
  import strap_seq_pkg::*;
#(
  parameter int WINDOW_CYCLES = 66000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STRAP_W-1:0] pad_in,
  input  logic              reg_override,
  input  logic [FSEL_W-1:0]  reg_fsel,
  output logic              pad_oe,
  output logic              clk_hold,
  output logic              strap_valid,
  output logic [FSEL_W-1:0]  fsel_eff,
  output logic              strap_mode,
  output logic              swing_2v5
);
  logic [STRAP_W-1:0] pad_sync;
  logic               capture;
  phase_e             phase;
  strap_t             straps;

  strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pad_sync)
  );

  window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .capture(capture), .phase(phase)
  );

  strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .d(strap_t'(pad_sync)), .q(straps), .valid(strap_valid)
  );

  fsel_mux u_mux (
    .strap_fsel(straps.fsel), .override(reg_override),
    .reg_fsel(reg_fsel), .fsel(fsel_eff)
  );

  assign pad_oe     = (phase == PH_RUN);
  assign clk_hold   = ~pad_oe;
  assign strap_mode = straps.mode;
  assign swing_2v5  = straps.swing;

  a_r2_no_drive_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> strap_valid);
  a_r4_enable_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_valid) |=> $rose(pad_oe));
  a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |=> strap_valid);
endmodule

// File: tb/strap_seq_tb.sv
module strap_seq_tb;
  localparam int CLK_P = 10;
  localparam int WIN   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pad_in = '0;
  logic       reg_override = 1'b0;
  logic [2:0] reg_fsel = '0;
  logic       pad_oe, clk_hold, strap_valid, strap_mode, swing_2v5;
  logic [2:0] fsel_eff;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  strap_seq #(.WINDOW_CYCLES(WIN), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .reg_override(reg_override),
    .reg_fsel(reg_fsel), .pad_oe(pad_oe), .clk_hold(clk_hold),
    .strap_valid(strap_valid), .fsel_eff(fsel_eff),
    .strap_mode(strap_mode), .swing_2v5(swing_2v5)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Assert reset with given pads, release on a falling edge.
  task automatic start(input logic [4:0] pads);
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = pads;
    edges(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 clk_hold", clk_hold, 1);
    chk("R1 strap_valid", strap_valid, 0);
    chk("R1 mode/swing", {strap_mode, swing_2v5}, 0);
    chk("R1 fsel", fsel_eff, 0);
  endtask

  task automatic t_window_and_capture;
    start(5'b1_0_101);
    edges(WIN - 1);
    chk("R2 valid low in window", strap_valid, 0);
    chk("R2 oe low in window", pad_oe, 0);
    chk("R2 hold in window", clk_hold, 1);
    edges(1);
    chk("R3 valid at capture edge", strap_valid, 1);
    chk("R3 fsel captured", fsel_eff, 5);
    chk("R3 mode captured", strap_mode, 0);
    chk("R7 swing 2.5V", swing_2v5, 1);
    chk("R4 oe still low at capture", pad_oe, 0);
    edges(1);
    chk("R4 oe high", pad_oe, 1);
    chk("R4 hold released", clk_hold, 0);
  endtask

  task automatic t_ignore_late_pads;
    pad_in = 5'b0_1_010;
    edges(6);
    chk("R5 fsel unchanged", fsel_eff, 5);
    chk("R5 mode unchanged", strap_mode, 0);
    chk("R5 swing unchanged", swing_2v5, 1);
    chk("R4 oe stays high", pad_oe, 1);
  endtask

  task automatic t_override;
    reg_fsel = 3'd2;
    reg_override = 1'b1;
    #1;
    chk("R6 override fsel", fsel_eff, 2);
    reg_fsel = 3'd7;
    #1;
    chk("R6 override follows reg", fsel_eff, 7);
    reg_override = 1'b0;
    #1;
    chk("R6 strap fsel restored", fsel_eff, 5);
  endtask

  task automatic t_reset_recapture;
    start(5'b0_1_011);
    #1;
    chk("R9 cleared by reset", strap_valid, 0);
    edges(WIN);
    chk("R9 recaptured valid", strap_valid, 1);
    chk("R9 new fsel", fsel_eff, 3);
    chk("R9 new mode", strap_mode, 1);
    chk("R7 swing 3.3V", swing_2v5, 0);
  endtask

  task automatic t_sync_late;
    start(5'b0_0_001);
    edges(WIN - 2);
    pad_in = 5'b0_0_110;
    edges(2);
    chk("R8 late change not captured", fsel_eff, 1);
  endtask

  task automatic t_sync_early;
    start(5'b0_0_001);
    edges(WIN - 3);
    pad_in = 5'b1_1_110;
    edges(3);
    chk("R8 early change captured fsel", fsel_eff, 6);
    chk("R8 early change captured mode", strap_mode, 1);
  endtask

  initial begin
    t_reset_state();
    t_window_and_capture();
    t_ignore_late_pads();
    t_override();
    t_reset_recapture();
    t_sync_late();
    t_sync_early();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule